// File: doc/BRIEF.md
# Debug Channel Transmit Mailbox with Privilege Trap Decision

This block holds the single 32-bit word that a processor core sends to an external debugger, together with a full flag that coordinates the two sides. When the core asks to write the word, the block first decides whether the write is allowed. That decision uses the current exception level, whether each level runs in 64-bit or 32-bit state, and a set of trap-control bits. The block reports the result one cycle later as one of two outcomes. In the first, the word is accepted: the data is stored and the full flag is set. In the second, a trap is raised, with its target level, its class and a syndrome code. A trapped write leaves the mailbox untouched.

The core can ask for a write in two ways: a direct register move or a word loaded from memory. The two kinds differ only in the syndrome code they report. While the core is halted for debug, every write is accepted without looking at any trap control. The debugger reads the word through a separate read strobe, and the read empties the mailbox. If the core writes again before the debugger has read the previous word, the new word replaces the old one and the block raises an overrun pulse.

Top module: `dbg_tx_mailbox`

## Requirements
- R1: After reset, `tx_full` is 0, `dbg_rd_data` is 0, and `commit`, `trap_valid` and `overrun` are all 0.
- R2: Each write request gives exactly one outcome, one cycle later: either a `commit` pulse or a `trap_valid` pulse, never both. After a commit, `tx_full` is 1 and `dbg_rd_data` holds the written word.
- R3: When `core_halted` is 1, every write commits, whatever the level, the state flags and the trap controls.
- R4: The syndrome is 0x05 for a register move (`core_wr_is_load`=0) and 0x06 for a memory load (`core_wr_is_load`=1). There are two exceptions, both reporting a syndrome of 0x00: the hypervisor trap raised by the user-disable check, and every monitor or undefined outcome.
- R5: Class encoding: 0 is system-access, 1 is hypervisor, 2 is monitor, 3 is undefined. This R5 check applies at level 0 when EL1 is 64-bit and `ctl_el1_user_trap` is 1. The write then traps as system-access. Its target is level 2 if EL2 is enabled, 64-bit and has `ctl_el2_tge` set; otherwise its target is level 1.
- R6: This check applies at level 0 when EL1 is 32-bit and `ctl_el1_user_dis` is 1. If EL2 is enabled, 64-bit and has TGE set, the write traps as system-access to level 2. If EL2 is enabled, 32-bit and has TGE set, it traps as hypervisor to level 2 with syndrome 0x00. In every other case it is undefined, with target level 1 and syndrome 0x00.
- R7: At levels 0 and 1, with EL2 enabled, three checks follow in order. First, the EL2 channel trap bit, which at level 1 in 64-bit EL2 counts only when `fgt_present` is 1. Second, any of TDE or TDA; at level 0 only, TGE also counts here. Third, the EL3 checks. A 64-bit EL2 gives system-access to level 2; a 32-bit EL2 gives hypervisor to level 2.
- R8: The EL3 checks apply only when EL3 is present. At level 2 they are the only checks. They run in this order, and if none fires the write commits:
  - In a 64-bit EL3, the EL3 channel trap bit with `fgt_present` gives system-access to level 3.
  - In a 32-bit EL3, the secure channel trap bit gives a monitor trap to level 3.
  - In a 64-bit EL3, the EL3 TDA bit gives system-access to level 3.
- R9: At level 3, the write gives a monitor trap to level 3 only when `core_in_monitor` is 0 and `ctl_sec_chan_trap` is 1. Otherwise it commits.
- R10: A trapped write changes neither `dbg_rd_data` nor `tx_full`.
- R11: A `dbg_rd` pulse returns the stored word and clears `tx_full` at the next edge. When a read and a committing write fall in the same cycle, `tx_full` stays 1 and the new word is kept.
- R12: If a write commits while `tx_full` is 1 and no read falls in the same cycle, the block raises a one-cycle `overrun` pulse alongside the `commit`, and the new word replaces the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_wr_req | input | 1 | Core write request, one cycle |
| core_wr_data | input | 32 | Word to transmit |
| core_wr_is_load | input | 1 | 1 = word loaded from memory, 0 = register move |
| core_halted | input | 1 | Core is in halted debug state |
| core_el | input | 2 | Current exception level |
| core_in_monitor | input | 1 | Level 3 is running in Monitor mode |
| el1_is64 | input | 1 | EL1 runs 64-bit |
| el2_is64 | input | 1 | EL2 runs 64-bit |
| el3_is64 | input | 1 | EL3 runs 64-bit |
| el2_enabled | input | 1 | EL2 is enabled |
| el3_present | input | 1 | EL3 is implemented |
| fgt_present | input | 1 | Fine-grained trap feature present |
| ctl_el1_user_trap | input | 1 | 64-bit EL1 user channel trap |
| ctl_el1_user_dis | input | 1 | 32-bit EL1 user channel disable |
| ctl_el2_tge | input | 1 | EL2 general trap enable |
| ctl_el2_chan_trap | input | 1 | EL2 channel trap |
| ctl_el2_tde | input | 1 | EL2 debug exception route |
| ctl_el2_tda | input | 1 | EL2 debug access trap |
| ctl_el3_chan_trap | input | 1 | 64-bit EL3 channel trap |
| ctl_sec_chan_trap | input | 1 | 32-bit secure channel trap |
| ctl_el3_tda | input | 1 | 64-bit EL3 debug access trap |
| dbg_rd | input | 1 | Debugger read strobe |
| dbg_rd_data | output | 32 | Stored word |
| tx_full | output | 1 | Mailbox holds an unread word |
| commit | output | 1 | Write accepted (pulse) |
| overrun | output | 1 | Accepted write replaced an unread word |
| trap_valid | output | 1 | Write trapped (pulse) |
| trap_level | output | 2 | Trap target level |
| trap_class | output | 2 | Trap class |
| trap_syndrome | output | 8 | Syndrome code |

## Verification
Some properties are checked on every cycle:
- commit and trap never occur together;
- a commit always leaves the flag set and the new word stored;
- a trap leaves the stored word as it was;
- a halted write always commits;
- a read with no write clears the flag;
- system-access syndromes are always 0x05 or 0x06;
- monitor traps always target level 3.

Only the directed scenarios can show that the priority chain picks the right outcome when several controls are set at once. The same holds for fine-grained gating at level 1 versus level 0, the user-disable three-way split, and overrun against a simultaneous read.

// File: rtl/dbg_tx_pkg.sv
package dbg_tx_pkg;
  localparam int SYND_W = 8;
  localparam int LVL_W  = 2;

  typedef enum logic [1:0] {
    TC_SYSACC = 2'd0,
    TC_HYP    = 2'd1,
    TC_MON    = 2'd2,
    TC_UNDEF  = 2'd3
  } trap_class_e;

  typedef struct packed {
    logic              trap;
    logic [LVL_W-1:0]  lvl;
    trap_class_e       cls;
    logic [SYND_W-1:0] syn;
  } trap_res_t;

  localparam logic [SYND_W-1:0] SYN_MOVE = 8'h05;
  localparam logic [SYND_W-1:0] SYN_LOAD = 8'h06;
  localparam logic [SYND_W-1:0] SYN_NONE = 8'h00;

  function automatic trap_res_t mk_trap(input logic [LVL_W-1:0] lvl,
                                        input trap_class_e cls,
                                        input logic [SYND_W-1:0] syn);
    trap_res_t r;
    r.trap = 1'b1;
    r.lvl  = lvl;
    r.cls  = cls;
    r.syn  = syn;
    return r;
  endfunction
endpackage

// File: rtl/dbg_tx_trap_eval.sv
module dbg_tx_trap_eval
  import dbg_tx_pkg::*;
(
  input  logic       is_load,
  input  logic       halted,
  input  logic [1:0] el,
  input  logic       in_monitor,
  input  logic       el1_is64,
  input  logic       el2_is64,
  input  logic       el3_is64,
  input  logic       el2_en,
  input  logic       el3_en,
  input  logic       fgt,
  input  logic       user_trap,
  input  logic       user_dis,
  input  logic       tge,
  input  logic       el2_chan,
  input  logic       tde,
  input  logic       tda2,
  input  logic       el3_chan,
  input  logic       sec_chan,
  input  logic       tda3,
  output trap_res_t  res
);
  logic [SYND_W-1:0] code;
  logic              e2_64, e2_32;
  trap_res_t         el3_res;

  assign code  = is_load ? SYN_LOAD : SYN_MOVE;
  assign e2_64 = el2_en && el2_is64;
  assign e2_32 = el2_en && !el2_is64;

  // Checks owned by the highest level, shared by levels 0..2 (R8)
  always_comb begin
    el3_res = '0;
    if (el3_en && el3_is64 && fgt && el3_chan)
      el3_res = mk_trap(2'd3, TC_SYSACC, code);
    else if (el3_en && !el3_is64 && sec_chan)
      el3_res = mk_trap(2'd3, TC_MON, SYN_NONE);
    else if (el3_en && el3_is64 && tda3)
      el3_res = mk_trap(2'd3, TC_SYSACC, code);
  end

  always_comb begin
    res = '0;
    if (halted) begin
      res = '0;
    end else begin
      unique case (el)
        2'd0: begin
          if (el1_is64 && user_trap)
            res = mk_trap(e2_64 && tge ? 2'd2 : 2'd1, TC_SYSACC, code);
          else if (!el1_is64 && user_dis) begin
            if (e2_64 && tge)      res = mk_trap(2'd2, TC_SYSACC, code);
            else if (e2_32 && tge) res = mk_trap(2'd2, TC_HYP, SYN_NONE);
            else                   res = mk_trap(2'd1, TC_UNDEF, SYN_NONE);
          end
          else if (e2_64 && el2_chan)               res = mk_trap(2'd2, TC_SYSACC, code);
          else if (e2_32 && el2_chan)               res = mk_trap(2'd2, TC_HYP, code);
          else if (e2_64 && (tge || tde || tda2))   res = mk_trap(2'd2, TC_SYSACC, code);
          else if (e2_32 && (tge || tde || tda2))   res = mk_trap(2'd2, TC_HYP, code);
          else                                      res = el3_res;
        end
        2'd1: begin
          if (e2_64 && fgt && el2_chan)             res = mk_trap(2'd2, TC_SYSACC, code);
          else if (e2_32 && el2_chan)               res = mk_trap(2'd2, TC_HYP, code);
          else if (e2_64 && (tde || tda2))          res = mk_trap(2'd2, TC_SYSACC, code);
          else if (e2_32 && (tde || tda2))          res = mk_trap(2'd2, TC_HYP, code);
          else                                      res = el3_res;
        end
        2'd2: res = el3_res;
        default: begin
          if (!in_monitor && sec_chan) res = mk_trap(2'd3, TC_MON, SYN_NONE);
        end
      endcase
    end
  end
endmodule

// File: rtl/dbg_tx_result_reg.sv
module dbg_tx_result_reg
  import dbg_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  trap_res_t         res,
  output logic              commit_q,
  output logic              trap_q,
  output logic [LVL_W-1:0]  lvl_q,
  output logic [1:0]        cls_q,
  output logic [SYND_W-1:0] syn_q
);
  logic              commit_d, trap_d;
  logic [LVL_W-1:0]  lvl_d;
  logic [1:0]        cls_d;
  logic [SYND_W-1:0] syn_d;

  always_comb begin
    commit_d = req && !res.trap;
    trap_d   = req && res.trap;
    lvl_d    = trap_d ? res.lvl : '0;
    cls_d    = trap_d ? res.cls : '0;
    syn_d    = trap_d ? res.syn : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_q <= 1'b0;
      trap_q   <= 1'b0;
      lvl_q    <= '0;
      cls_q    <= '0;
      syn_q    <= '0;
    end else begin
      commit_q <= commit_d;
      trap_q   <= trap_d;
      lvl_q    <= lvl_d;
      cls_q    <= cls_d;
      syn_q    <= syn_d;
    end
  end

  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_q && trap_q));
  assert_sysacc_syndrome_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_q && cls_q == TC_SYSACC) |-> (syn_q == SYN_MOVE || syn_q == SYN_LOAD));
  assert_monitor_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_q && cls_q == TC_MON) |-> (lvl_q == 2'd3));
endmodule

// File: rtl/dbg_tx_data_reg.sv
module dbg_tx_data_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] data_q,
  output logic              full_q,
  output logic              overrun_q
);
  logic [DATA_W-1:0] data_d;
  logic              full_d, overrun_d;

  always_comb begin
    data_d    = wr_en ? wr_data : data_q;
    full_d    = wr_en ? 1'b1 : (rd_en ? 1'b0 : full_q);
    overrun_d = wr_en && full_q && !rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q    <= '0;
      full_q    <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      if (wr_en) data_q <= data_d;
      full_q    <= full_d;
      overrun_q <= overrun_d;
    end
  end

  assert_commit_stores_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (full_q && data_q == $past(wr_data)));
  assert_hold_without_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(data_q));
  assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> !full_q);
  assert_overrun_full_R12: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_q |-> full_q);
endmodule

// File: rtl/dbg_tx_mailbox.sv
module dbg_tx_mailbox
  import dbg_tx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_wr_req,
  input  logic [DATA_W-1:0] core_wr_data,
  input  logic              core_wr_is_load,
  input  logic              core_halted,
  input  logic [1:0]        core_el,
  input  logic              core_in_monitor,
  input  logic              el1_is64,
  input  logic              el2_is64,
  input  logic              el3_is64,
  input  logic              el2_enabled,
  input  logic              el3_present,
  input  logic              fgt_present,
  input  logic              ctl_el1_user_trap,
  input  logic              ctl_el1_user_dis,
  input  logic              ctl_el2_tge,
  input  logic              ctl_el2_chan_trap,
  input  logic              ctl_el2_tde,
  input  logic              ctl_el2_tda,
  input  logic              ctl_el3_chan_trap,
  input  logic              ctl_sec_chan_trap,
  input  logic              ctl_el3_tda,
  input  logic              dbg_rd,
  output logic [DATA_W-1:0] dbg_rd_data,
  output logic              tx_full,
  output logic              commit,
  output logic              overrun,
  output logic              trap_valid,
  output logic [LVL_W-1:0]  trap_level,
  output logic [1:0]        trap_class,
  output logic [SYND_W-1:0] trap_syndrome
);
  trap_res_t dec;
  logic      wr_commit;

  dbg_tx_trap_eval u_eval (
    .is_load    (core_wr_is_load),
    .halted     (core_halted),
    .el         (core_el),
    .in_monitor (core_in_monitor),
    .el1_is64   (el1_is64),
    .el2_is64   (el2_is64),
    .el3_is64   (el3_is64),
    .el2_en     (el2_enabled),
    .el3_en     (el3_present),
    .fgt        (fgt_present),
    .user_trap  (ctl_el1_user_trap),
    .user_dis   (ctl_el1_user_dis),
    .tge        (ctl_el2_tge),
    .el2_chan   (ctl_el2_chan_trap),
    .tde        (ctl_el2_tde),
    .tda2       (ctl_el2_tda),
    .el3_chan   (ctl_el3_chan_trap),
    .sec_chan   (ctl_sec_chan_trap),
    .tda3       (ctl_el3_tda),
    .res        (dec)
  );

  assign wr_commit = core_wr_req && !dec.trap;

  dbg_tx_result_reg u_result (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (core_wr_req),
    .res      (dec),
    .commit_q (commit),
    .trap_q   (trap_valid),
    .lvl_q    (trap_level),
    .cls_q    (trap_class),
    .syn_q    (trap_syndrome)
  );

  dbg_tx_data_reg #(.DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_commit),
    .wr_data   (core_wr_data),
    .rd_en     (dbg_rd),
    .data_q    (dbg_rd_data),
    .full_q    (tx_full),
    .overrun_q (overrun)
  );

  assert_halted_commits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr_req && core_halted) |=> (commit && !trap_valid));
  assert_trap_keeps_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> $stable(dbg_rd_data));
endmodule

// File: tb/dbg_tx_mailbox_tb_top.sv
module dbg_tx_mailbox_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        core_wr_req, core_wr_is_load, core_halted, core_in_monitor;
  logic [31:0] core_wr_data;
  logic [1:0]  core_el;
  logic        el1_is64, el2_is64, el3_is64, el2_enabled, el3_present, fgt_present;
  logic        ctl_el1_user_trap, ctl_el1_user_dis, ctl_el2_tge, ctl_el2_chan_trap;
  logic        ctl_el2_tde, ctl_el2_tda, ctl_el3_chan_trap, ctl_sec_chan_trap, ctl_el3_tda;
  logic        dbg_rd;
  logic [31:0] dbg_rd_data;
  logic        tx_full, commit, overrun, trap_valid;
  logic [1:0]  trap_level, trap_class;
  logic [7:0]  trap_syndrome;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dbg_tx_mailbox dut_i (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    core_halted = 0; core_in_monitor = 0; core_el = 0;
    el1_is64 = 0; el2_is64 = 0; el3_is64 = 0; el2_enabled = 0; el3_present = 0; fgt_present = 0;
    ctl_el1_user_trap = 0; ctl_el1_user_dis = 0; ctl_el2_tge = 0; ctl_el2_chan_trap = 0;
    ctl_el2_tde = 0; ctl_el2_tda = 0; ctl_el3_chan_trap = 0; ctl_sec_chan_trap = 0; ctl_el3_tda = 0;
  endtask

  task automatic issue(input logic [31:0] d, input logic ld, input logic rd);
    @(negedge clk);
    core_wr_data = d; core_wr_is_load = ld; core_wr_req = 1; dbg_rd = rd;
    @(negedge clk);
    core_wr_req = 0; dbg_rd = 0;
  endtask

  task automatic read_out();
    @(negedge clk); dbg_rd = 1;
    @(negedge clk); dbg_rd = 0;
  endtask

  task automatic exp_commit(input string tag, input logic [31:0] d);
    chk({tag, " commit"}, commit, 1);
    chk({tag, " no trap"}, trap_valid, 0);
    chk({tag, " data"}, dbg_rd_data, d);
    chk({tag, " full"}, tx_full, 1);
  endtask

  task automatic exp_trap(input string tag, input logic [1:0] lvl, input logic [1:0] cls,
                          input logic [7:0] syn);
    chk({tag, " trap"}, trap_valid, 1);
    chk({tag, " no commit"}, commit, 0);
    chk({tag, " level"}, trap_level, lvl);
    chk({tag, " class"}, trap_class, cls);
    chk({tag, " syndrome"}, trap_syndrome, syn);
  endtask

  task automatic t_reset();
    chk("R1 full", tx_full, 0);
    chk("R1 data", dbg_rd_data, 0);
    chk("R1 commit", commit, 0);
    chk("R1 trap", trap_valid, 0);
    chk("R1 overrun", overrun, 0);
  endtask

  task automatic t_basic();
    clr(); core_el = 1;
    issue(32'hA5A5_0001, 0, 0);
    exp_commit("R2 basic", 32'hA5A5_0001);
    chk("R12 first write no overrun", overrun, 0);
    read_out();
    chk("R11 read clears", tx_full, 0);
    chk("R11 data kept", dbg_rd_data, 32'hA5A5_0001);
  endtask

  task automatic t_overrun();
    clr(); core_el = 2;
    issue(32'h1111_2222, 0, 0);
    chk("R12 no overrun when empty", overrun, 0);
    issue(32'h3333_4444, 1, 0);
    exp_commit("R12 overwrite", 32'h3333_4444);
    chk("R12 overrun pulse", overrun, 1);
    @(negedge clk);
    chk("R12 pulse ends", overrun, 0);
    issue(32'h5555_6666, 0, 1);
    chk("R11 simultaneous full", tx_full, 1);
    chk("R11 simultaneous data", dbg_rd_data, 32'h5555_6666);
    chk("R11 simultaneous no overrun", overrun, 0);
    read_out();
  endtask

  task automatic t_halted();
    clr(); core_halted = 1; core_el = 0; el2_enabled = 1; el3_present = 1; fgt_present = 1;
    ctl_el1_user_trap = 1; ctl_el1_user_dis = 1; ctl_el2_tge = 1; ctl_el2_chan_trap = 1;
    ctl_el2_tde = 1; ctl_el2_tda = 1; ctl_el3_chan_trap = 1; ctl_sec_chan_trap = 1; ctl_el3_tda = 1;
    issue(32'hDEAD_0003, 1, 0);
    exp_commit("R3 halted", 32'hDEAD_0003);
    core_el = 3;
    issue(32'hDEAD_0004, 0, 0);
    exp_commit("R3 halted el3", 32'hDEAD_0004);
    read_out();
  endtask

  task automatic t_el0_user();
    clr(); el1_is64 = 1; ctl_el1_user_trap = 1; el2_enabled = 1; el2_is64 = 1; ctl_el2_tge = 1;
    issue(32'h0BAD_0001, 0, 0);
    exp_trap("R5 tge to 2", 2, 0, 8'h05);
    chk("R10 full unchanged", tx_full, 0);
    chk("R10 data unchanged", dbg_rd_data, 32'hDEAD_0004);
    ctl_el2_tge = 0;
    issue(32'h0BAD_0002, 1, 0);
    exp_trap("R5 to 1 load R4", 1, 0, 8'h06);
    chk("R10 data unchanged 2", dbg_rd_data, 32'hDEAD_0004);
  endtask

  task automatic t_el0_udis();
    clr(); ctl_el1_user_dis = 1; el2_enabled = 1; el2_is64 = 1; ctl_el2_tge = 1;
    issue(32'h1, 1, 0);
    exp_trap("R6 64 tge", 2, 0, 8'h06);
    el2_is64 = 0;
    issue(32'h2, 1, 0);
    exp_trap("R6 32 tge hyp", 2, 1, 8'h00);
    el2_enabled = 0;
    issue(32'h3, 0, 0);
    exp_trap("R6 undefined", 1, 3, 8'h00);
  endtask

  task automatic t_el2_order();
    clr(); el2_enabled = 1; el2_is64 = 1; ctl_el2_chan_trap = 1;
    issue(32'h10, 0, 0);
    exp_trap("R7 el0 chan 64", 2, 0, 8'h05);
    el2_is64 = 0;
    issue(32'h11, 1, 0);
    exp_trap("R7 el0 chan 32", 2, 1, 8'h06);
    clr(); el2_enabled = 1; el2_is64 = 1; ctl_el2_tge = 1;
    issue(32'h12, 0, 0);
    exp_trap("R7 el0 tge", 2, 0, 8'h05);
    core_el = 1;
    issue(32'h13, 0, 0);
    exp_commit("R7 el1 tge ignored", 32'h13);
    ctl_el2_tge = 0; ctl_el2_chan_trap = 1;
    issue(32'h14, 0, 0);
    exp_commit("R7 el1 chan without fgt", 32'h14);
    fgt_present = 1;
    issue(32'h15, 0, 0);
    exp_trap("R7 el1 chan with fgt", 2, 0, 8'h05);
    clr(); core_el = 1; el2_enabled = 1; ctl_el2_tda = 1; el3_present = 1; el3_is64 = 1; ctl_el3_tda = 1;
    issue(32'h16, 1, 0);
    exp_trap("R7 el1 tda32 beats el3", 2, 1, 8'h06);
    read_out();
  endtask

  task automatic t_el3_checks();
    clr(); core_el = 2; el3_present = 1; el3_is64 = 1; ctl_el3_chan_trap = 1;
    el2_enabled = 1; el2_is64 = 1; ctl_el2_chan_trap = 1; ctl_el2_tde = 1;
    issue(32'h20, 0, 0);
    exp_commit("R8 el2 ignores el2 bits no fgt", 32'h20);
    fgt_present = 1;
    issue(32'h21, 1, 0);
    exp_trap("R8 el3 chan", 3, 0, 8'h06);
    clr(); core_el = 2; el3_present = 1; el3_is64 = 0; ctl_sec_chan_trap = 1; ctl_el3_tda = 1;
    issue(32'h22, 0, 0);
    exp_trap("R8 secure monitor", 3, 2, 8'h00);
    clr(); core_el = 0; el3_present = 1; el3_is64 = 1; ctl_el3_tda = 1; ctl_sec_chan_trap = 1;
    issue(32'h23, 0, 0);
    exp_trap("R8 el3 tda", 3, 0, 8'h05);
    el3_present = 0;
    issue(32'h24, 0, 0);
    exp_commit("R8 absent el3", 32'h24);
    read_out();
  endtask

  task automatic t_el3_level();
    clr(); core_el = 3; ctl_sec_chan_trap = 1;
    issue(32'h30, 1, 0);
    exp_trap("R9 not monitor", 3, 2, 8'h00);
    core_in_monitor = 1;
    issue(32'h31, 1, 0);
    exp_commit("R9 monitor mode", 32'h31);
    read_out();
  endtask

  initial begin
    rst_n = 0; core_wr_req = 0; core_wr_data = 0; core_wr_is_load = 0; dbg_rd = 0;
    clr();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_overrun();
    t_halted();
    t_el0_user();
    t_el0_udis();
    t_el2_order();
    t_el3_checks();
    t_el3_level();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule